// File: doc/BRIEF.md
# Calibration Coefficient Byte Read Front End

This block sits between a host register bus and a small byte-wide store of calibration coefficients. Every output channel owns two 16-bit coefficients, an offset and a gain, and each coefficient is held as two bytes. The host fetches one byte per command. It writes a 16-bit command word that names the channel, the coefficient and the byte half. It then polls a status word until the completion flag rises, and reads the byte from the upper half of that same word. A full coefficient therefore takes two commanded reads.

A command with its top bit clear writes one byte into the store. While that write is in progress the status word shows a busy flag. The store is modelled as a synchronous byte array. It answers a fixed, parameterised number of cycles after each request. Only one access can be in flight at a time. Any command that arrives while an access is outstanding is dropped.

Top module: `cal_coef_if`

## Requirements
- R1: After reset the status word (offset 1) and the command read-back word (offset 0) both read 0000h, and every byte of the store holds 00h.
- R2: A command word written at offset 0 with bit 15 = 1 starts a read of byte address {bits 12:10, bits 9:8}. Bits 12:10 are the channel. Bits 9:8 select the byte: 00 offset high byte, 01 offset low byte, 10 gain high byte, 11 gain low byte.
- R3: Status bit 0 (done) rises exactly LAT+1 clock edges after the edge that accepts a read command, and never earlier.
- R4: While done is 1, status bits 15:8 carry the byte that was read. While done is 0, those bits read 00h.
- R5: An accepted command clears done from the very next cycle.
- R6: A command with bit 15 = 0 writes bits 7:0 into the selected byte. Status bit 1 (busy) reads 1 for the LAT+1 cycles that follow the accepting edge and 0 afterwards. Done stays 0 throughout.
- R7: A command written while a read or a write is outstanding is ignored. It changes neither the access in flight, nor the store, nor the command read-back word.
- R8: Status bits 7:2 always read 0. Offset 0 reads back the last accepted command word.
- R9: Writes to any offset other than 0 have no effect, and reads of offsets 2 and 3 return 0000h.
- R10: Done and busy are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | 1 = write access, 0 = read access |
| host_addr | input | ADDR_W | Register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data; valid during a selected read, 0 otherwise |

## Verification
The read-back word changes one edge after the accepting write, because that edge loads the command register. Done and the byte it carries appear LAT+1 edges after that write. The memory needs LAT edges to answer, and the sequencer needs one more to capture the answer. Busy follows the same window: it is high from the first cycle after the write and clears at edge LAT+1.

The bench drives and samples on the falling clock edge. After each command it reads the status word once per cycle across the whole window. So a flag that rises one cycle early or one cycle late shows up as a mismatch in the exact cycle where it occurs.

// File: rtl/cal_pkg.sv
// Package: field positions of the command and status words, and the
// sequencer state type shared by the coefficient front end.
package cal_pkg;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int CMD_RD   = 15;  // 1 = read request, 0 = write request
    localparam int CMD_SEL0 = 8;   // two-bit byte selector starts here
    localparam int CMD_CH0  = 10;  // channel field starts here
    localparam int CMD_CHW  = 3;   // channel field width in the command word
    localparam int ST_DONE  = 0;
    localparam int ST_BUSY  = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cal_bus_decode.sv
// Host register decode. Offset 0 is the command word (write, plus read-back
// of the last accepted command) and offset 1 is the status word (read only).
// Assumes single-cycle host accesses; read data is combinational.
module cal_bus_decode #(
    parameter int ADDR_W = 2
) (
    input  logic                      host_sel,
    input  logic                      host_wr,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [cal_pkg::WORD_W-1:0] host_wdata,
    input  logic [cal_pkg::WORD_W-1:0] cmd_word,
    input  logic [cal_pkg::WORD_W-1:0] status_word,
    output logic                      cmd_stb,
    output logic [cal_pkg::WORD_W-1:0] cmd_data,
    output logic [cal_pkg::WORD_W-1:0] host_rdata
);
    localparam logic [ADDR_W-1:0] OFS_CMD    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(1);

    // Write strobe toward the sequencer: only the command offset is writable.
    always_comb begin
        cmd_stb  = host_sel && host_wr && (host_addr == OFS_CMD);
        cmd_data = host_wdata;
    end

    // Read mux: unused offsets and idle cycles return zero.
    always_comb begin
        host_rdata = '0;
        if (host_sel && !host_wr) begin
            if (host_addr == OFS_CMD)         host_rdata = cmd_word;
            else if (host_addr == OFS_STATUS) host_rdata = status_word;
        end
    end
endmodule

// File: rtl/cal_byte_mem.sv
// Coefficient byte store model. It takes one request at a time and completes
// it LAT edges later with a one-cycle ack; reads return data with the ack.
// Assumes the requester never issues a new request before the ack.
module cal_byte_mem #(
    parameter int AW  = 5,
    parameter int LAT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic                       we,
    input  logic [AW-1:0]              addr,
    input  logic [cal_pkg::BYTE_W-1:0] wbyte,
    output logic                       ack,
    output logic [cal_pkg::BYTE_W-1:0] rbyte
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(LAT + 1) + 1;

    logic [cal_pkg::BYTE_W-1:0] mem_q [DEPTH];
    logic [CW-1:0]              cnt_q;
    logic                       we_q;
    logic [AW-1:0]              addr_q;
    logic [cal_pkg::BYTE_W-1:0] wbyte_q;

    // Latency counter, request capture and the access at the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wbyte_q <= '0;
            ack     <= 1'b0;
            rbyte   <= '0;
        end else begin
            ack <= 1'b0;
            if (req) begin
                cnt_q   <= CW'(LAT);
                we_q    <= we;
                addr_q  <= addr;
                wbyte_q <= wbyte;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    ack <= 1'b1;
                    if (we_q) mem_q[addr_q] <= wbyte_q;
                    else      rbyte         <= mem_q[addr_q];
                end
            end
        end
    end
endmodule

// File: rtl/cal_seq.sv
// Access sequencer. It accepts a command only when idle, issues one memory
// request, and on the ack either latches the byte and sets done (read) or
// drops busy (write). Commands seen while not idle are dropped.
module cal_seq #(
    parameter int MEM_AW = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_stb,
    input  logic [cal_pkg::WORD_W-1:0] cmd_data,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [MEM_AW-1:0]          mem_addr,
    output logic [cal_pkg::BYTE_W-1:0] mem_wbyte,
    input  logic                       mem_ack,
    input  logic [cal_pkg::BYTE_W-1:0] mem_rbyte,
    output logic [cal_pkg::WORD_W-1:0] cmd_q,
    output logic                       done,
    output logic                       busy,
    output logic [cal_pkg::BYTE_W-1:0] byte_q
);
    import cal_pkg::*;
    localparam int CH_AW = MEM_AW - 2;

    seq_state_e state_q;
    logic       accept;

    // Acceptance and the request fields are taken straight from the command.
    always_comb begin
        accept    = cmd_stb && (state_q == SEQ_IDLE);
        mem_req   = accept;
        mem_we    = !cmd_data[CMD_RD];
        mem_addr  = {cmd_data[CMD_CH0 +: CH_AW], cmd_data[CMD_SEL0 +: 2]};
        mem_wbyte = cmd_data[BYTE_W-1:0];
        busy      = (state_q == SEQ_WRITE);
    end

    // State, command copy, done flag and returned byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cmd_q   <= '0;
            done    <= 1'b0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        cmd_q   <= cmd_data;
                        done    <= 1'b0;
                        byte_q  <= '0;
                        state_q <= cmd_data[CMD_RD] ? SEQ_READ : SEQ_WRITE;
                    end
                end
                SEQ_READ: begin
                    if (mem_ack) begin
                        done    <= 1'b1;
                        byte_q  <= mem_rbyte;
                        state_q <= SEQ_IDLE;
                    end
                end
                SEQ_WRITE: begin
                    if (mem_ack) state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cal_coef_if.sv
// Top of the calibration coefficient byte read front end: bus decode,
// access sequencer and the latency-modelled byte store. NUM_CH must be a
// power of two between 2 and 8; LAT must lie between 1 and 250.
module cal_coef_if #(
    parameter int NUM_CH = 8,
    parameter int LAT    = 4,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata
);
    localparam int MEM_AW = $clog2(NUM_CH) + 2;

    logic                       cmd_stb;
    logic [15:0]                cmd_data;
    logic [15:0]                cmd_q;
    logic [15:0]                status_word;
    logic                       mem_req;
    logic                       mem_we;
    logic [MEM_AW-1:0]          mem_addr;
    logic [7:0]                 mem_wbyte;
    logic                       mem_ack;
    logic [7:0]                 mem_rbyte;
    logic                       done;
    logic                       busy;
    logic [7:0]                 byte_q;

    // Status word layout: byte in 15:8, padding zero, busy in 1, done in 0.
    always_comb begin
        status_word = {byte_q, 6'b000000, busy, done};
    end

    cal_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cmd_word   (cmd_q),
        .status_word(status_word),
        .cmd_stb    (cmd_stb),
        .cmd_data   (cmd_data),
        .host_rdata (host_rdata)
    );

    cal_seq #(.MEM_AW(MEM_AW)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_stb  (cmd_stb),
        .cmd_data (cmd_data),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wbyte(mem_wbyte),
        .mem_ack  (mem_ack),
        .mem_rbyte(mem_rbyte),
        .cmd_q    (cmd_q),
        .done     (done),
        .busy     (busy),
        .byte_q   (byte_q)
    );

    cal_byte_mem #(.AW(MEM_AW), .LAT(LAT)) mem_i (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (mem_req),
        .we   (mem_we),
        .addr (mem_addr),
        .wbyte(mem_wbyte),
        .ack  (mem_ack),
        .rbyte(mem_rbyte)
    );
endmodule

// File: rtl/cal_coef_if_chk.sv
// Property checker for the coefficient front end, bound to the top module.
// It watches the status word and the memory request/ack handshake.
module cal_coef_if_chk #(
    parameter int LAT = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] status_word,
    input logic        mem_req,
    input logic        mem_we
);
    logic [7:0] since_q;

    // Edges elapsed since the last memory request, saturating at FFh.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= 8'hFF;
        else if (mem_req)          since_q <= 8'h00;
        else if (since_q != 8'hFF) since_q <= since_q + 8'h01;
    end

    assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7:2] == 6'b0);
    assert_done_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_word[0] && status_word[1]));
    assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[0]) |-> (since_q == 8'(LAT + 1)));
    assert_done_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !status_word[0]);
    assert_busy_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> status_word[1]);
    assert_single_inflight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_byte_hidden_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[0] |-> (status_word[15:8] == 8'h00));
endmodule

bind cal_coef_if cal_coef_if_chk #(.LAT(LAT)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_word(status_word),
    .mem_req    (mem_req),
    .mem_we     (mem_we)
);

// File: tb/cal_coef_if_tb_top.sv
// Bench: fills all 32 coefficient bytes and reads each back, checking the
// status word every cycle of each access window, then checks dropped
// commands and inactive offsets.
module cal_coef_if_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_coef_if #(.NUM_CH(8), .LAT(LAT), .ADDR_W(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_sel  (host_sel),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    function automatic logic [7:0] pattern(input int a);
        return 8'((a * 37 + 5) % 256);
    endfunction

    function automatic logic [15:0] cmd_word(input logic rd, input logic [4:0] a, input logic [7:0] b);
        return {rd, 2'b00, a, b};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] d);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #1;
        d = host_rdata;
        host_sel = 1'b0;
    endtask

    // Write one byte and check the busy window cycle by cycle (R6, R10).
    task automatic do_write(input logic [4:0] a, input logic [7:0] b);
        logic [15:0] st;
        bus_write(2'd0, cmd_word(1'b0, a, b));
        for (int k = 0; k <= LAT + 1; k++) begin
            peek(2'd1, st);
            check("R6 busy window", st, (k <= LAT) ? 16'h0002 : 16'h0000);
            if (k < LAT + 1) @(negedge clk);
        end
    endtask

    // Read one byte and check done timing and byte placement (R2-R5, R8).
    task automatic do_read(input logic [4:0] a, input logic [7:0] exp_b);
        logic [15:0] st;
        bus_write(2'd0, cmd_word(1'b1, a, 8'h00));
        for (int k = 0; k <= LAT + 1; k++) begin
            peek(2'd1, st);
            check((k == LAT + 1) ? "R2 R4 byte" : "R3 R5 done early", st,
                  (k == LAT + 1) ? {exp_b, 8'h01} : 16'h0000);
            if (k < LAT + 1) @(negedge clk);
        end
        peek(2'd0, st);
        check("R8 command read-back", st, cmd_word(1'b1, a, 8'h00));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        peek(2'd1, st); check("R1 status", st, 16'h0000);
        peek(2'd0, st); check("R1 cmd", st, 16'h0000);
        do_read(5'd9, 8'h00);  // R1: store cleared
        // Fill every byte, then read each back (R2, R6).
        for (int a = 0; a < 32; a++) do_write(5'(a), pattern(a));
        for (int a = 0; a < 32; a++) do_read(5'(a), pattern(a));
        // R7: a second read command while a read is pending is dropped.
        bus_write(2'd0, cmd_word(1'b1, 5'd3, 8'h00));
        bus_write(2'd0, cmd_word(1'b1, 5'd20, 8'h00));
        repeat (LAT) @(negedge clk);
        peek(2'd1, st); check("R7 pending read kept", st, {pattern(3), 8'h01});
        peek(2'd0, st); check("R7 cmd unchanged", st, cmd_word(1'b1, 5'd3, 8'h00));
        // R7: a write command during a write is dropped.
        bus_write(2'd0, cmd_word(1'b0, 5'd12, 8'h5A));
        bus_write(2'd0, cmd_word(1'b0, 5'd13, 8'hAA));
        repeat (LAT + 2) @(negedge clk);
        do_read(5'd13, pattern(13));
        do_read(5'd12, 8'h5A);
        // R9: writes to other offsets have no effect; unused offsets read 0.
        bus_write(2'd2, cmd_word(1'b1, 5'd1, 8'h00));
        bus_write(2'd3, cmd_word(1'b0, 5'd1, 8'h00));
        bus_write(2'd1, cmd_word(1'b0, 5'd1, 8'h00));
        repeat (LAT + 2) @(negedge clk);
        peek(2'd1, st); check("R9 status stable", st, {8'h5A, 8'h01});
        peek(2'd0, st); check("R9 cmd stable", st, cmd_word(1'b1, 5'd12, 8'h00));
        peek(2'd2, st); check("R9 offset 2", st, 16'h0000);
        peek(2'd3, st); check("R9 offset 3", st, 16'h0000);
        do_read(5'd1, pattern(1));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule